// File: doc/BRIEF.md
# Half-Cycle Read Latency Aligner

This block produces the timing of read data for a double-data-rate memory, either as a model of the memory side or as a reference timer inside a controller. It registers a read command, waits a programmed latency (2 or 3 clocks, or 1.5 or 2.5 clocks), and then raises a data-valid window. Data moves on both clock edges, so a burst of BL beats occupies BL/2 clock cycles. The window is reported as two flags: one for beats on the rising edge and one for beats on the falling edge.

A half-cycle latency is handled by starting the falling-edge flag one whole clock before the rising-edge flag. The first beat therefore lands on the falling edge. A pair of strobe-enable flags follows the same two edges. Each opens one half-cycle early as a preamble. The latency, burst length and speed-grade inputs are captured only while no read is in flight. An unsupported setting raises an error flag and drops reads.

All outputs are registered. An output value present after rising edge k describes edge k (the `_rise` flag) and the falling edge that follows it (the `_fall` flag).

Top module: `rd_lat_aligner`

## Requirements
- R1: While reset is high, and on the cycle after it, every output is low.
- R2: With an integer latency m (code 3'b010 for 2, 3'b011 for 3), a read registered at edge n sets both dv_rise and dv_fall after edges n+m through n+m+BL/2-1 and nowhere else.
- R3: With a half-cycle latency m (code 3'b101 for 1.5, 3'b110 for 2.5; bit 2 is the half flag and bits 1:0 the whole part w), dv_fall is set after edges n+w through n+w+BL/2-1 and dv_rise after edges n+w+1 through n+w+BL/2.
- R4: bl_sel values 0, 1 and 2 select bursts of 2, 4 and 8 beats, which is a window of 1, 2 and 4 clocks on each edge flag.
- R5: Reads spaced exactly BL/2 clocks apart give one unbroken window on each edge flag, with no gap.
- R6: dqs_en_rise is set after edge k when either beat of cycle k is valid. dqs_en_fall is set when the falling beat of cycle k or the rising beat of cycle k+1 is valid. This gives a one-edge preamble.
- R7: With fast_grade low the legal latency codes are 1.5, 2 and 2.5. With fast_grade high they are 2, 2.5 and 3. Any other latency code, or bl_sel of 3, sets lat_err after that edge, and a read issued at that edge produces no output.
- R8: lat_code, bl_sel and fast_grade are captured at an edge only when no read is in flight. A change during a burst takes effect for the first read issued after the block has drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_cmd | input | 1 | Read command, registered at the rising edge |
| fast_grade | input | 1 | Speed grade: 1 selects the fastest grade's latency set |
| lat_code | input | 3 | Latency code: bit 2 = half cycle, bits 1:0 = whole clocks |
| bl_sel | input | 2 | Burst length select: 2 << bl_sel beats |
| dv_rise | output | 1 | Data beat valid on this rising edge |
| dv_fall | output | 1 | Data beat valid on the following falling edge |
| dqs_en_rise | output | 1 | Strobe enable on this rising edge |
| dqs_en_fall | output | 1 | Strobe enable on the following falling edge |
| lat_err | output | 1 | Captured latency or burst setting is unsupported |

## Verification
Some relations are checked on every cycle: with an integer latency the two edge flags agree, and with a half latency the rising flag repeats the previous cycle's falling flag. They also confirm that the strobe enables cover every valid beat, that an error flag never coincides with valid data, and that the captured setting stays stable while reads are in flight. The exact placement of a window relative to its command is shown only by the bench scenarios. So are the window lengths for each burst size, the absence of gaps between back-to-back reads, the rejection of codes per speed grade, and the deferral of mid-burst setting changes.

// File: rtl/rla_pkg.sv
package rla_pkg;

  typedef struct packed {
    logic       half;
    logic [1:0] whole;
  } lat_code_t;

  function automatic logic lat_ok(input lat_code_t c, input logic fast);
    logic ok;
    case ({c.half, c.whole})
      3'b101:  ok = !fast;
      3'b010:  ok = 1'b1;
      3'b110:  ok = 1'b1;
      3'b011:  ok = fast;
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/rla_cfg.sv
module rla_cfg
  import rla_pkg::*;
#(
  parameter int BL_SEL_W   = 2,
  parameter int MAX_BL_LOG = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                idle,
  input  logic [2:0]          lat_in,
  input  logic [BL_SEL_W-1:0] bl_in,
  input  logic                fast_in,
  output lat_code_t           lat_eff,
  output logic [BL_SEL_W-1:0] bl_eff,
  output logic                legal_eff,
  output logic                cur_half,
  output logic                err_q
);

  lat_code_t           lat_q;
  logic [BL_SEL_W-1:0] bl_q;
  logic                fast_q;
  logic                fast_eff;

  always_comb begin
    if (idle) begin
      lat_eff  = lat_code_t'(lat_in);
      bl_eff   = bl_in;
      fast_eff = fast_in;
    end else begin
      lat_eff  = lat_q;
      bl_eff   = bl_q;
      fast_eff = fast_q;
    end
    legal_eff = lat_ok(lat_eff, fast_eff) && (int'(bl_eff) < MAX_BL_LOG);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q  <= '0;
      bl_q   <= '0;
      fast_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (idle) begin
        lat_q  <= lat_eff;
        bl_q   <= bl_eff;
        fast_q <= fast_eff;
      end
      err_q <= !legal_eff;
    end
  end

  assign cur_half = lat_q.half;

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !idle |=> ($stable(lat_q) && $stable(bl_q) && $stable(fast_q))); // R8

endmodule

// File: rtl/rla_window.sv
module rla_window #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] load_val,
  output logic             act_q,
  output logic             act_d
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (start) begin
      cnt_d = load_val;
      act_d = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
      act_d = 1'b1;
    end else begin
      cnt_d = '0;
      act_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  AST_WIN_ENDS: assert property (@(posedge clk) disable iff (rst)
    (act_q && cnt_q == '0 && !start) |=> !act_q); // R4

  AST_WIN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |=> act_q); // R5

endmodule

// File: rtl/rd_lat_aligner.sv
module rd_lat_aligner
  import rla_pkg::*;
#(
  parameter int MAX_LAT    = 3,
  parameter int MAX_BL_LOG = 3,
  parameter int BL_SEL_W   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_cmd,
  input  logic                fast_grade,
  input  logic [2:0]          lat_code,
  input  logic [BL_SEL_W-1:0] bl_sel,
  output logic                dv_rise,
  output logic                dv_fall,
  output logic                dqs_en_rise,
  output logic                dqs_en_fall,
  output logic                lat_err
);

  localparam int PIPE_D   = MAX_LAT - 1;
  localparam int MAX_HALF = 1 << (MAX_BL_LOG - 1);
  localparam int CNT_W    = (MAX_HALF > 1) ? $clog2(MAX_HALF) : 1;

  lat_code_t           lat_eff;
  logic [BL_SEL_W-1:0] bl_eff;
  logic                legal_eff, cur_half, idle, rd_ok;
  logic [PIPE_D-1:0]   pipe_q;
  logic [MAX_LAT-1:0]  cmd_vec;
  logic [1:0]          win_q, win_d;
  logic [CNT_W-1:0]    load_val;

  rla_cfg #(.BL_SEL_W(BL_SEL_W), .MAX_BL_LOG(MAX_BL_LOG)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .idle      (idle),
    .lat_in    (lat_code),
    .bl_in     (bl_sel),
    .fast_in   (fast_grade),
    .lat_eff   (lat_eff),
    .bl_eff    (bl_eff),
    .legal_eff (legal_eff),
    .cur_half  (cur_half),
    .err_q     (lat_err)
  );

  assign idle     = (pipe_q == '0) && (win_q == 2'b00);
  assign rd_ok    = rd_cmd && legal_eff;
  assign cmd_vec  = {pipe_q, rd_ok};
  assign load_val = CNT_W'((1 << bl_eff) - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe_q <= '0;
    end else begin
      pipe_q[0] <= rd_ok;
      for (int i = 1; i < PIPE_D; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  // Edge 0 = falling-edge beats (delay = whole), edge 1 = rising (whole + half).
  for (genvar e = 0; e < 2; e++) begin : g_edge
    logic start;
    always_comb begin
      int d;
      d = (e == 0) ? int'(lat_eff.whole) : int'(lat_eff.whole) + int'(lat_eff.half);
      start = 1'b0;
      for (int i = 0; i < MAX_LAT; i++)
        if (d == i + 1) start = cmd_vec[i];
    end
    rla_window #(.CNT_W(CNT_W)) u_win (
      .clk      (clk),
      .rst      (rst),
      .start    (start),
      .load_val (load_val),
      .act_q    (win_q[e]),
      .act_d    (win_d[e])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dv_rise     <= 1'b0;
      dv_fall     <= 1'b0;
      dqs_en_rise <= 1'b0;
      dqs_en_fall <= 1'b0;
    end else begin
      dv_rise     <= win_q[1];
      dv_fall     <= win_q[0];
      dqs_en_rise <= win_q[1] | win_q[0];
      dqs_en_fall <= win_q[0] | win_d[1];
    end
  end

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    lat_err |-> (!dv_rise && !dv_fall)); // R7

  AST_INT_PAIR: assert property (@(posedge clk) disable iff (rst)
    !cur_half |-> (dv_rise == dv_fall)); // R2

  AST_HALF_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (cur_half && $past(cur_half)) |-> (dv_rise == $past(dv_fall))); // R3

  AST_EN_RISE_COVER: assert property (@(posedge clk) disable iff (rst)
    dv_rise |-> dqs_en_rise); // R6

  AST_EN_FALL_COVER: assert property (@(posedge clk) disable iff (rst)
    dv_fall |-> dqs_en_fall); // R6

endmodule

// File: tb/rd_lat_aligner_test.sv
module rd_lat_aligner_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rd_cmd = 1'b0;
  logic       fast_grade = 1'b0;
  logic [2:0] lat_code = 3'b010;
  logic [1:0] bl_sel = 2'd1;
  logic       dv_rise, dv_fall, dqs_en_rise, dqs_en_fall, lat_err;

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";
  bit    finished = 0;

  always #5 clk = ~clk;

  rd_lat_aligner uut (
    .clk(clk), .rst(rst), .rd_cmd(rd_cmd), .fast_grade(fast_grade),
    .lat_code(lat_code), .bl_sel(bl_sel), .dv_rise(dv_rise), .dv_fall(dv_fall),
    .dqs_en_rise(dqs_en_rise), .dqs_en_fall(dqs_en_fall), .lat_err(lat_err)
  );

  // Reference model: expected beats scheduled per edge index.
  int k = 0;
  int last_end = -100;
  int m_lat = 0, m_bl = 0;
  bit m_fast = 0;
  bit exp_r[int];
  bit exp_f[int];
  bit exp_err[int];

  function automatic bit legal(int lat, int bl, bit fast);
    bit ok_lat;
    ok_lat = (lat == 2) || (lat == 6) || (lat == 5 && !fast) || (lat == 3 && fast);
    return ok_lat && (bl <= 2);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      k = 0;
      last_end = -100;
    end else begin
      k = k + 1;
      if (k - 1 > last_end) begin
        m_lat = int'(lat_code);
        m_bl = int'(bl_sel);
        m_fast = fast_grade;
      end
      exp_err[k] = !legal(m_lat, m_bl, m_fast);
      if (rd_cmd && legal(m_lat, m_bl, m_fast)) begin
        int h, fd, rdl;
        h = 1 << m_bl;
        fd = m_lat % 4;
        rdl = fd + m_lat / 4;
        for (int i = 0; i < h; i++) begin
          exp_f[k + fd + i] = 1'b1;
          exp_r[k + rdl + i] = 1'b1;
        end
        if (k + rdl + h - 2 > last_end) last_end = k + rdl + h - 2;
      end
    end
  end

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at edge %0d: actual %b expected %b", req, what, k, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && k > 0) begin
      bit r0, f0, r1, e0;
      r0 = exp_r.exists(k) ? exp_r[k] : 1'b0;
      f0 = exp_f.exists(k) ? exp_f[k] : 1'b0;
      r1 = exp_r.exists(k + 1) ? exp_r[k + 1] : 1'b0;
      e0 = exp_err.exists(k) ? exp_err[k] : 1'b0;
      check(tag, "dv_rise", dv_rise, r0);
      check(tag, "dv_fall", dv_fall, f0);
      check("R6", "dqs_en_rise", dqs_en_rise, r0 | f0);
      check("R6", "dqs_en_fall", dqs_en_fall, f0 | r1);
      check("R7", "lat_err", lat_err, e0);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_once();
    @(negedge clk);
    rd_cmd = 1'b1;
    @(negedge clk);
    rd_cmd = 1'b0;
  endtask

  task automatic setup(input bit fast, input logic [2:0] lat, input logic [1:0] bl);
    @(negedge clk);
    fast_grade = fast;
    lat_code = lat;
    bl_sel = bl;
  endtask

  task automatic single(input bit fast, input logic [2:0] lat, input logic [1:0] bl);
    setup(fast, lat, bl);
    read_once();
    wait_cyc(10);
  endtask

  task automatic stream(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rd_cmd = 1'b1;
      @(negedge clk);
      rd_cmd = 1'b0;
      if (gap > 1) wait_cyc(gap - 1);
    end
    wait_cyc(10);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    wait_cyc(3);
    check("R1", "dv_rise in reset", dv_rise, 1'b0);
    check("R1", "dv_fall in reset", dv_fall, 1'b0);
    check("R1", "dqs_en_rise in reset", dqs_en_rise, 1'b0);
    check("R1", "dqs_en_fall in reset", dqs_en_fall, 1'b0);
    check("R1", "lat_err in reset", lat_err, 1'b0);
    rst = 1'b0;
    wait_cyc(2);

    tag = "R2";
    single(1'b0, 3'b010, 2'd1);
    single(1'b1, 3'b010, 2'd1);
    single(1'b1, 3'b011, 2'd1);

    tag = "R3";
    single(1'b0, 3'b101, 2'd1);
    single(1'b0, 3'b110, 2'd1);
    single(1'b1, 3'b110, 2'd2);

    tag = "R4";
    for (int b = 0; b < 3; b++) begin
      single(1'b0, 3'b010, b[1:0]);
      single(1'b0, 3'b101, b[1:0]);
    end

    tag = "R5";
    setup(1'b0, 3'b110, 2'd2);
    stream(4, 4);
    setup(1'b0, 3'b101, 2'd0);
    stream(5, 1);
    setup(1'b1, 3'b011, 2'd1);
    stream(4, 2);

    tag = "R7";
    single(1'b0, 3'b011, 2'd1);
    single(1'b1, 3'b101, 2'd1);
    single(1'b0, 3'b000, 2'd1);
    single(1'b0, 3'b111, 2'd1);
    single(1'b0, 3'b010, 2'd3);
    single(1'b0, 3'b010, 2'd0);

    tag = "R8";
    setup(1'b1, 3'b011, 2'd2);
    @(negedge clk);
    rd_cmd = 1'b1;
    @(negedge clk);
    rd_cmd = 1'b0;
    lat_code = 3'b010;
    bl_sel = 2'd0;
    wait_cyc(3);
    rd_cmd = 1'b1;
    @(negedge clk);
    rd_cmd = 1'b0;
    lat_code = 3'b000;
    wait_cyc(12);
    lat_code = 3'b010;
    read_once();
    wait_cyc(10);

    tag = "R5";
    for (int c = 0; c < 600; c++) begin
      @(negedge clk);
      rd_cmd = ($urandom_range(0, 2) == 0);
      if ($urandom_range(0, 15) == 0) begin
        fast_grade = $urandom_range(0, 1);
        lat_code = 3'($urandom_range(0, 7));
        bl_sel = 2'($urandom_range(0, 3));
      end
    end
    rd_cmd = 1'b0;
    wait_cyc(15);

    finish_run();
  end

endmodule